// File: doc/BRIEF.md
# Transmit Slot Scheduler

This block owns a small set of transmit message slots for a CAN-style bus controller. Each slot has a control byte: a pending-request bit, a two-bit priority and three outcome flags (aborted, lost arbitration, bus error). Each slot also has a payload store for its identifier, length and data bytes. When the bus is free, the block chooses one pending slot and hands its index to a bit-level protocol engine with a one-cycle start pulse. It then waits for exactly one of three outcome pulses from that engine: success, bus error or lost arbitration.

A failed attempt leaves the request pending, so the slot is offered again at the next chance. A successful attempt retires the request and raises a per-slot done flag. The host can withdraw a request, or cancel every queued request with a level-sensitive abort-all input, but only for slots whose transmission has not begun. Once a slot has been launched it stays locked until it succeeds. One interrupt line combines the per-slot done flags and a global message-error flag, each through its own enable.

Top module: `txq_scheduler`

## Requirements
- R1: The control byte read for a slot carries aborted at bit 6, lost arbitration at bit 5, bus error at bit 4, request at bit 3 and priority at bits 1:0. Bits 7 and 2 always read 0, and every control byte reads 0x00 after reset.
- R2: A start pulse of exactly one cycle is issued, with `tx_slot` giving the chosen index, only when `bus_idle` is high, `abort_all` is low and no transmission is in flight. The chosen slot is the pending slot with the numerically largest priority (3 highest, 0 lowest).
- R3: When pending slots share the top priority, the one with the largest index is chosen.
- R4: A control write with bit 3 set to a slot that has not been launched sets its request, loads the priority from bits 1:0, and clears its aborted, lost-arbitration and bus-error flags.
- R5: A success pulse clears the launched slot's request and sets its done flag. `irq` is high whenever any done flag has its enable set or the message-error flag has its enable set.
- R6: A bus-error pulse keeps the launched slot's request, sets its bus-error flag and sets the global message-error flag.
- R7: A lost-arbitration pulse keeps the request and sets the slot's lost-arbitration flag, and the slot is offered again at the next arbitration.
- R8: A control write with bit 3 clear withdraws the request of a slot that has not been launched, without setting its aborted flag. Any control write to a slot between its launch and its success is ignored.
- R9: While `abort_all` is high, every pending slot that has not been launched loses its request and gets its aborted flag set, and no start is issued. A launched slot keeps its request and is retried after `abort_all` falls.
- R10: A payload write to a slot whose request is set is ignored. Writes to slots without a request are stored and read back unchanged.
- R11: `done_clr` and `merr_clr` clear the corresponding flags, and a flag set in the same cycle as its clear stays set.
- R12: Arbitration is redone after every outcome, so a request posted while another slot was in flight competes at the next idle cycle on equal terms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctrl_wr_en | input | 1 | Control byte write strobe |
| ctrl_wr_slot | input | SLOT_W | Slot addressed by the control write |
| ctrl_wr_data | input | 8 | Control byte (bit 3 request, bits 1:0 priority) |
| ctrl_rd_slot | input | SLOT_W | Slot whose control byte is read |
| ctrl_rd_data | output | 8 | Control byte of `ctrl_rd_slot` |
| pl_wr_en | input | 1 | Payload write strobe |
| pl_wr_slot | input | SLOT_W | Slot addressed by the payload write |
| pl_wr_addr | input | ADDR_W | Byte offset within the slot payload |
| pl_wr_data | input | 8 | Payload byte |
| pl_rd_slot | input | SLOT_W | Slot for payload read (host or engine) |
| pl_rd_addr | input | ADDR_W | Byte offset for payload read |
| pl_rd_data | output | 8 | Payload byte read |
| abort_all | input | 1 | Level abort-all control |
| done_ie | input | NUM_SLOTS | Per-slot done interrupt enables |
| merr_ie | input | 1 | Message-error interrupt enable |
| done_clr | input | NUM_SLOTS | Per-slot done flag clears |
| merr_clr | input | 1 | Message-error flag clear |
| done_flags | output | NUM_SLOTS | Per-slot transmit-done flags |
| merr_flag | output | 1 | Global message-error flag |
| irq | output | 1 | Combined interrupt |
| bus_idle | input | 1 | Bus available for a new frame |
| tx_start | output | 1 | One-cycle launch pulse to the protocol engine |
| tx_slot | output | SLOT_W | Index of the launched slot |
| tx_ok | input | 1 | Engine reports success |
| tx_bus_err | input | 1 | Engine reports a bus error |
| tx_lost_arb | input | 1 | Engine reports lost arbitration |

## Verification
The bench goes after priority ties, where a design that breaks ties toward the lower index launches the wrong slot, and after a retry following lost arbitration or a bus error, where a design that drops the request never sends the frame again. It tries to withdraw or abort a slot that has already been launched, which a faulty lock would let through, and it checks that `abort_all` blocks every start and spares only the launched slot. It also hits a flag clear in the same cycle as a new error, which a design with the wrong set/clear priority loses, and it writes payload into a pending slot, which an unguarded store would corrupt.

// File: rtl/txq_pkg.sv
package txq_pkg;

   localparam int PRIO_W     = 2;
   localparam int CTL_ABORT  = 6;
   localparam int CTL_LOST   = 5;
   localparam int CTL_BUSERR = 4;
   localparam int CTL_REQ    = 3;

   typedef enum logic {
      ST_IDLE   = 1'b0,
      ST_ACTIVE = 1'b1
   } txq_state_e;

   typedef struct packed {
      logic              aborted;
      logic              lost;
      logic              buserr;
      logic              req;
      logic [PRIO_W-1:0] prio;
   } txq_slot_t;

   function automatic logic [7:0] txq_pack(txq_slot_t s);
      return {1'b0, s.aborted, s.lost, s.buserr, s.req, 1'b0, s.prio};
   endfunction

endpackage

// File: rtl/txq_slot_ctrl.sv
module txq_slot_ctrl
   import txq_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_hit,
   input  logic              wr_req,
   input  logic [PRIO_W-1:0] wr_prio,
   input  logic              launch,
   input  logic              res_ok,
   input  logic              res_err,
   input  logic              res_lost,
   input  logic              abort_all,
   input  logic              clr_done,
   output txq_slot_t         st,
   output logic              done_flag
);

   logic begun_q;
   logic guard;
   logic set_now;

   // A slot is locked from the cycle it is launched until it succeeds.
   assign guard   = begun_q | launch;
   assign set_now = wr_hit & wr_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= '0;
         done_flag <= 1'b0;
         begun_q   <= 1'b0;
      end else begin
         if (launch) begun_q <= 1'b1;

         if (wr_hit && !guard) begin
            st.prio <= wr_prio;
            if (wr_req) begin
               st.req     <= 1'b1;
               st.aborted <= 1'b0;
               st.lost    <= 1'b0;
               st.buserr  <= 1'b0;
            end else begin
               st.req <= 1'b0;
            end
         end

         // Abort-all overrides a same-cycle host request.
         if (abort_all && !guard && (st.req || set_now)) begin
            st.req     <= 1'b0;
            st.aborted <= 1'b1;
         end

         if (res_ok) begin
            st.req  <= 1'b0;
            begun_q <= 1'b0;
         end
         if (res_err)  st.buserr <= 1'b1;
         if (res_lost) st.lost   <= 1'b1;

         if (res_ok)        done_flag <= 1'b1;
         else if (clr_done) done_flag <= 1'b0;
      end
   end

endmodule

// File: rtl/txq_arbiter.sv
module txq_arbiter
   import txq_pkg::*;
#(
   parameter int NUM_SLOTS = 3,
   parameter int SLOT_W    = 2
)(
   input  logic [NUM_SLOTS-1:0]        req,
   input  logic [NUM_SLOTS*PRIO_W-1:0] prio_flat,
   output logic                        any,
   output logic [SLOT_W-1:0]           winner
);

   logic [PRIO_W-1:0] best;

   // Ascending scan with >= : equal priority lets the later (higher) index win.
   always_comb begin
      any    = 1'b0;
      winner = '0;
      best   = '0;
      for (int i = 0; i < NUM_SLOTS; i++) begin
         if (req[i] && (!any || prio_flat[i*PRIO_W +: PRIO_W] >= best)) begin
            any    = 1'b1;
            winner = SLOT_W'(i);
            best   = prio_flat[i*PRIO_W +: PRIO_W];
         end
      end
   end

endmodule

// File: rtl/txq_payload_store.sv
module txq_payload_store #(
   parameter int NUM_SLOTS = 3,
   parameter int BYTES     = 13,
   parameter int SLOT_W    = 2,
   parameter int ADDR_W    = 4
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [SLOT_W-1:0]    wr_slot,
   input  logic [ADDR_W-1:0]    wr_addr,
   input  logic [7:0]           wr_data,
   input  logic [NUM_SLOTS-1:0] lock,
   input  logic [SLOT_W-1:0]    rd_slot,
   input  logic [ADDR_W-1:0]    rd_addr,
   output logic [7:0]           rd_data
);

   localparam logic [ADDR_W:0] BYTES_L = (ADDR_W+1)'(BYTES);
   localparam logic [SLOT_W:0] SLOTS_L = (SLOT_W+1)'(NUM_SLOTS);

   logic [7:0] bank_rd [NUM_SLOTS];
   logic       wr_in_range;
   logic       rd_in_range;

   assign wr_in_range = ({1'b0, wr_addr} < BYTES_L);
   assign rd_in_range = ({1'b0, rd_addr} < BYTES_L);

   for (genvar b = 0; b < NUM_SLOTS; b++) begin : g_bank
      logic [7:0] mem [BYTES];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < BYTES; i++) mem[i] <= '0;
         end else if (wr_en && wr_slot == SLOT_W'(b) && wr_in_range && !lock[b]) begin
            mem[wr_addr] <= wr_data;
         end
      end

      assign bank_rd[b] = rd_in_range ? mem[rd_addr] : 8'h00;
   end

   always_comb begin
      if ({1'b0, rd_slot} < SLOTS_L) rd_data = bank_rd[rd_slot];
      else                           rd_data = 8'h00;
   end

endmodule

// File: rtl/txq_scheduler.sv
module txq_scheduler
   import txq_pkg::*;
#(
   parameter int NUM_SLOTS     = 3,
   parameter int PAYLOAD_BYTES = 13,
   localparam int SLOT_W = $clog2(NUM_SLOTS),
   localparam int ADDR_W = (PAYLOAD_BYTES > 1) ? $clog2(PAYLOAD_BYTES) : 1
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ctrl_wr_en,
   input  logic [SLOT_W-1:0]    ctrl_wr_slot,
   input  logic [7:0]           ctrl_wr_data,
   input  logic [SLOT_W-1:0]    ctrl_rd_slot,
   output logic [7:0]           ctrl_rd_data,
   input  logic                 pl_wr_en,
   input  logic [SLOT_W-1:0]    pl_wr_slot,
   input  logic [ADDR_W-1:0]    pl_wr_addr,
   input  logic [7:0]           pl_wr_data,
   input  logic [SLOT_W-1:0]    pl_rd_slot,
   input  logic [ADDR_W-1:0]    pl_rd_addr,
   output logic [7:0]           pl_rd_data,
   input  logic                 abort_all,
   input  logic [NUM_SLOTS-1:0] done_ie,
   input  logic                 merr_ie,
   input  logic [NUM_SLOTS-1:0] done_clr,
   input  logic                 merr_clr,
   output logic [NUM_SLOTS-1:0] done_flags,
   output logic                 merr_flag,
   output logic                 irq,
   input  logic                 bus_idle,
   output logic                 tx_start,
   output logic [SLOT_W-1:0]    tx_slot,
   input  logic                 tx_ok,
   input  logic                 tx_bus_err,
   input  logic                 tx_lost_arb
);

   if (NUM_SLOTS < 2 || NUM_SLOTS > 16) begin : g_bad_slots
      $error("txq_scheduler: NUM_SLOTS must lie in 2..16");
   end
   if (PAYLOAD_BYTES < 1 || PAYLOAD_BYTES > 64) begin : g_bad_bytes
      $error("txq_scheduler: PAYLOAD_BYTES must lie in 1..64");
   end

   localparam logic [SLOT_W:0] SLOTS_L = (SLOT_W+1)'(NUM_SLOTS);

   txq_state_e                 state_q;
   logic [SLOT_W-1:0]          cur_q;
   logic                       start_q;
   logic                       in_flight;
   logic                       go;
   logic                       any_pend;
   logic [SLOT_W-1:0]          win;
   logic                       res_ok, res_err, res_lost;
   logic [NUM_SLOTS-1:0]       req_vec;
   logic [NUM_SLOTS*PRIO_W-1:0] prio_flat;
   txq_slot_t                  slot_st [NUM_SLOTS];
   logic                       merr_q;
   logic                       unused_ctrl_bits;

   assign unused_ctrl_bits = ^{ctrl_wr_data[7:4], ctrl_wr_data[2]};

   assign in_flight = (state_q == ST_ACTIVE);
   assign go        = !in_flight && bus_idle && !abort_all && any_pend;
   // One outcome per attempt; success outranks error outranks lost arbitration.
   assign res_ok    = in_flight && tx_ok;
   assign res_err   = in_flight && !tx_ok && tx_bus_err;
   assign res_lost  = in_flight && !tx_ok && !tx_bus_err && tx_lost_arb;

   txq_arbiter #(
      .NUM_SLOTS (NUM_SLOTS),
      .SLOT_W    (SLOT_W)
   ) u_arb (
      .req       (req_vec),
      .prio_flat (prio_flat),
      .any       (any_pend),
      .winner    (win)
   );

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
      logic here;
      assign here = (cur_q == SLOT_W'(i));

      txq_slot_ctrl u_ctrl (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_hit    (ctrl_wr_en && ctrl_wr_slot == SLOT_W'(i)),
         .wr_req    (ctrl_wr_data[CTL_REQ]),
         .wr_prio   (ctrl_wr_data[PRIO_W-1:0]),
         .launch    (go && win == SLOT_W'(i)),
         .res_ok    (res_ok && here),
         .res_err   (res_err && here),
         .res_lost  (res_lost && here),
         .abort_all (abort_all),
         .clr_done  (done_clr[i]),
         .st        (slot_st[i]),
         .done_flag (done_flags[i])
      );

      assign req_vec[i]                      = slot_st[i].req;
      assign prio_flat[i*PRIO_W +: PRIO_W]   = slot_st[i].prio;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cur_q   <= '0;
         start_q <= 1'b0;
         merr_q  <= 1'b0;
      end else begin
         start_q <= go;
         case (state_q)
            ST_IDLE: begin
               if (go) begin
                  state_q <= ST_ACTIVE;
                  cur_q   <= win;
               end
            end
            ST_ACTIVE: begin
               if (res_ok || res_err || res_lost) state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
         if (res_err)       merr_q <= 1'b1;
         else if (merr_clr) merr_q <= 1'b0;
      end
   end

   txq_payload_store #(
      .NUM_SLOTS (NUM_SLOTS),
      .BYTES     (PAYLOAD_BYTES),
      .SLOT_W    (SLOT_W),
      .ADDR_W    (ADDR_W)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (pl_wr_en),
      .wr_slot (pl_wr_slot),
      .wr_addr (pl_wr_addr),
      .wr_data (pl_wr_data),
      .lock    (req_vec),
      .rd_slot (pl_rd_slot),
      .rd_addr (pl_rd_addr),
      .rd_data (pl_rd_data)
   );

   always_comb begin
      if ({1'b0, ctrl_rd_slot} < SLOTS_L) ctrl_rd_data = txq_pack(slot_st[ctrl_rd_slot]);
      else                                ctrl_rd_data = 8'h00;
   end

   assign tx_start  = start_q;
   assign tx_slot   = cur_q;
   assign merr_flag = merr_q;
   assign irq       = (|(done_flags & done_ie)) | (merr_q & merr_ie);

endmodule

// File: rtl/txq_scheduler_chk.sv
module txq_scheduler_chk #(
   parameter int NUM_SLOTS = 3,
   parameter int SLOT_W    = 2
)(
   input logic                 clk,
   input logic                 rst_n,
   input logic                 bus_idle,
   input logic                 abort_all,
   input logic                 tx_start,
   input logic                 in_flight,
   input logic [SLOT_W-1:0]    cur_slot,
   input logic [NUM_SLOTS-1:0] req_vec,
   input logic                 tx_ok,
   input logic                 tx_bus_err,
   input logic                 tx_lost_arb,
   input logic                 merr_flag
);

   p_start_needs_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start |-> $past(bus_idle));

   p_start_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start |=> !tx_start);

   p_ok_retires_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_flight && tx_ok) |=> !req_vec[$past(cur_slot)]);

   p_err_keeps_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_flight && !tx_ok && tx_bus_err) |=> (req_vec[$past(cur_slot)] && merr_flag));

   p_lost_keeps_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_flight && !tx_ok && !tx_bus_err && tx_lost_arb) |=> req_vec[$past(cur_slot)]);

   p_launched_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_flight && !tx_ok) |=> req_vec[$past(cur_slot)]);

   p_no_start_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start |-> !$past(abort_all));

endmodule

bind txq_scheduler txq_scheduler_chk #(
   .NUM_SLOTS (NUM_SLOTS),
   .SLOT_W    (SLOT_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_idle    (bus_idle),
   .abort_all   (abort_all),
   .tx_start    (tx_start),
   .in_flight   (in_flight),
   .cur_slot    (cur_q),
   .req_vec     (req_vec),
   .tx_ok       (tx_ok),
   .tx_bus_err  (tx_bus_err),
   .tx_lost_arb (tx_lost_arb),
   .merr_flag   (merr_flag)
);

// File: tb/tb_txq_scheduler.sv
module tb_txq_scheduler;

   localparam int NS = 3;
   localparam int NB = 13;
   localparam int SW = 2;
   localparam int AW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ctrl_wr_en = 1'b0;
   logic [SW-1:0] ctrl_wr_slot = '0;
   logic [7:0]    ctrl_wr_data = '0;
   logic [SW-1:0] ctrl_rd_slot = '0;
   logic [7:0]    ctrl_rd_data;
   logic          pl_wr_en = 1'b0;
   logic [SW-1:0] pl_wr_slot = '0;
   logic [AW-1:0] pl_wr_addr = '0;
   logic [7:0]    pl_wr_data = '0;
   logic [SW-1:0] pl_rd_slot = '0;
   logic [AW-1:0] pl_rd_addr = '0;
   logic [7:0]    pl_rd_data;
   logic          abort_all = 1'b0;
   logic [NS-1:0] done_ie = '0;
   logic          merr_ie = 1'b0;
   logic [NS-1:0] done_clr = '0;
   logic          merr_clr = 1'b0;
   logic [NS-1:0] done_flags;
   logic          merr_flag;
   logic          irq;
   logic          bus_idle = 1'b0;
   logic          tx_start;
   logic [SW-1:0] tx_slot;
   logic          tx_ok = 1'b0;
   logic          tx_bus_err = 1'b0;
   logic          tx_lost_arb = 1'b0;

   txq_scheduler #(.NUM_SLOTS(NS), .PAYLOAD_BYTES(NB)) dut (
      .clk(clk), .rst_n(rst_n),
      .ctrl_wr_en(ctrl_wr_en), .ctrl_wr_slot(ctrl_wr_slot), .ctrl_wr_data(ctrl_wr_data),
      .ctrl_rd_slot(ctrl_rd_slot), .ctrl_rd_data(ctrl_rd_data),
      .pl_wr_en(pl_wr_en), .pl_wr_slot(pl_wr_slot), .pl_wr_addr(pl_wr_addr), .pl_wr_data(pl_wr_data),
      .pl_rd_slot(pl_rd_slot), .pl_rd_addr(pl_rd_addr), .pl_rd_data(pl_rd_data),
      .abort_all(abort_all), .done_ie(done_ie), .merr_ie(merr_ie),
      .done_clr(done_clr), .merr_clr(merr_clr),
      .done_flags(done_flags), .merr_flag(merr_flag), .irq(irq),
      .bus_idle(bus_idle), .tx_start(tx_start), .tx_slot(tx_slot),
      .tx_ok(tx_ok), .tx_bus_err(tx_bus_err), .tx_lost_arb(tx_lost_arb)
   );

   always #5 clk = ~clk;

   int  n_cmp = 0;
   int  n_bad = 0;
   bit  finished = 1'b0;

   // Reference model of the requirements
   bit         m_req [NS];
   bit [1:0]   m_prio [NS];
   bit         m_abt [NS];
   bit         m_lost [NS];
   bit         m_err [NS];
   bit         m_begun [NS];
   bit [NS-1:0] m_done;
   bit         m_merr;
   bit [7:0]   m_pay [NS][NB];
   int         m_cur;

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   function automatic int pick();
      int best = -1;
      for (int i = 0; i < NS; i++)
         if (m_req[i] && (best < 0 || m_prio[i] >= m_prio[best])) best = i;
      return best;
   endfunction

   function automatic bit [7:0] exp_ctrl(int s);
      return {1'b0, m_abt[s], m_lost[s], m_err[s], m_req[s], 1'b0, m_prio[s]};
   endfunction

   function automatic bit exp_irq();
      return (|(m_done & done_ie)) | (m_merr & merr_ie);
   endfunction

   function automatic void apply_abort();
      for (int i = 0; i < NS; i++)
         if (!m_begun[i] && m_req[i]) begin
            m_req[i] = 1'b0;
            m_abt[i] = 1'b1;
         end
   endfunction

   task automatic check_ctrl(string tag);
      for (int s = 0; s < NS; s++) begin
         ctrl_rd_slot = SW'(s);
         #1;
         chk({tag, " ctrl byte"}, 32'(ctrl_rd_data), 32'(exp_ctrl(s)));
      end
   endtask

   task automatic wr_ctrl(int s, bit [7:0] d);
      ctrl_wr_en = 1'b1; ctrl_wr_slot = SW'(s); ctrl_wr_data = d;
      tick();
      ctrl_wr_en = 1'b0;
      if (!m_begun[s]) begin
         m_prio[s] = d[1:0];
         if (d[3]) begin
            m_req[s] = 1'b1; m_abt[s] = 1'b0; m_lost[s] = 1'b0; m_err[s] = 1'b0;
         end else begin
            m_req[s] = 1'b0;
         end
      end
      if (abort_all) apply_abort();
   endtask

   task automatic do_launch(string tag, output int w);
      w = abort_all ? -1 : pick();
      bus_idle = 1'b1;
      tick();
      bus_idle = 1'b0;
      if (abort_all) apply_abort();
      chk({tag, " start"}, 32'(tx_start), 32'(w >= 0));
      if (w >= 0) begin
         chk({tag, " chosen slot"}, 32'(tx_slot), 32'(w));
         m_begun[w] = 1'b1;
         m_cur = w;
      end
   endtask

   // kind: 0 success, 1 bus error, 2 lost arbitration
   task automatic do_outcome(string tag, int kind, bit clrm);
      tx_ok = (kind == 0); tx_bus_err = (kind == 1); tx_lost_arb = (kind == 2);
      merr_clr = clrm;
      tick();
      tx_ok = 1'b0; tx_bus_err = 1'b0; tx_lost_arb = 1'b0; merr_clr = 1'b0;
      if (abort_all) apply_abort();
      case (kind)
         0: begin m_req[m_cur] = 1'b0; m_begun[m_cur] = 1'b0; m_done[m_cur] = 1'b1; end
         1: begin m_err[m_cur] = 1'b1; m_merr = 1'b1; end
         default: m_lost[m_cur] = 1'b1;
      endcase
      if (clrm && kind != 1) m_merr = 1'b0;
      chk({tag, " done flags"}, 32'(done_flags), 32'(m_done));
      chk({tag, " merr flag"}, 32'(merr_flag), 32'(m_merr));
      chk({tag, " R5 irq"}, 32'(irq), 32'(exp_irq()));
      check_ctrl(tag);
   endtask

   task automatic clr_flags(bit [NS-1:0] mask, bit m);
      done_clr = mask; merr_clr = m;
      tick();
      done_clr = '0; merr_clr = 1'b0;
      m_done = m_done & ~mask;
      if (m) m_merr = 1'b0;
      chk("R11 done flags after clear", 32'(done_flags), 32'(m_done));
      chk("R11 merr after clear", 32'(merr_flag), 32'(m_merr));
   endtask

   task automatic wr_pl(int s, int a, bit [7:0] d);
      pl_wr_en = 1'b1; pl_wr_slot = SW'(s); pl_wr_addr = AW'(a); pl_wr_data = d;
      tick();
      pl_wr_en = 1'b0;
      if (!m_req[s]) m_pay[s][a] = d;
   endtask

   task automatic rd_pl(string tag, int s, int a);
      pl_rd_slot = SW'(s); pl_rd_addr = AW'(a);
      #1;
      chk(tag, 32'(pl_rd_data), 32'(m_pay[s][a]));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      int w;
      int unsigned seed_init;
      seed_init = $urandom(32'd20240611);
      for (int i = 0; i < NS; i++) begin
         m_req[i] = 0; m_prio[i] = 0; m_abt[i] = 0; m_lost[i] = 0; m_err[i] = 0; m_begun[i] = 0;
         for (int j = 0; j < NB; j++) m_pay[i][j] = 8'h00;
      end
      m_done = '0; m_merr = 1'b0; m_cur = 0;

      repeat (3) tick();
      rst_n = 1'b1;
      tick();

      // R1: reset state
      check_ctrl("R1 reset");
      chk("R1 reset start", 32'(tx_start), 0);
      chk("R1 reset irq", 32'(irq), 0);

      // R4: request + priority; R1: pad bits ignored and read 0
      wr_ctrl(0, 8'h0B);
      wr_ctrl(1, 8'h86);
      check_ctrl("R4 R1 write");

      // R2: highest priority wins (slot0 prio3 against slot1 prio1, slot2 prio2)
      wr_ctrl(1, 8'h09);
      wr_ctrl(2, 8'h0A);
      done_ie = 3'b001;
      do_launch("R2 highest priority", w);
      do_outcome("R5 success", 0, 1'b0);
      clr_flags(3'b001, 1'b0);

      // R3: tie at priority 2 between slot1 and slot2 goes to slot2
      wr_ctrl(1, 8'h0A);
      merr_ie = 1'b1;
      do_launch("R3 tie", w);
      do_outcome("R6 bus error", 1, 1'b0);

      // R8: launched slot ignores a withdrawing write; R7: retry after loss
      wr_ctrl(2, 8'h00);
      check_ctrl("R8 launched locked");
      do_launch("R7 retry after error", w);
      do_outcome("R7 lost arbitration", 2, 1'b0);
      do_launch("R7 retry after loss", w);
      do_outcome("R7 final success", 0, 1'b0);

      // R8: withdraw a pending, unlaunched slot; aborted flag stays clear
      wr_ctrl(1, 8'h02);
      check_ctrl("R8 withdraw");
      do_launch("R8 nothing pending", w);
      clr_flags(3'b111, 1'b1);

      // R9: abort-all spares only the launched slot and blocks starts
      wr_ctrl(0, 8'h08);
      wr_ctrl(1, 8'h0B);
      do_launch("R9 pre-abort", w);
      do_outcome("R9 launched slot errs", 1, 1'b0);
      abort_all = 1'b1;
      tick();
      apply_abort();
      check_ctrl("R9 abort all");
      do_launch("R9 blocked while abort", w);
      wr_ctrl(2, 8'h0B);
      check_ctrl("R9 request under abort");
      abort_all = 1'b0;
      do_launch("R9 retry after abort", w);
      do_outcome("R9 retry success", 0, 1'b0);

      // R10: payload write protection
      wr_ctrl(0, 8'h08);
      wr_pl(0, 5, 8'hAA);
      wr_pl(1, 5, 8'h55);
      wr_pl(1, 12, 8'h3C);
      rd_pl("R10 locked slot payload", 0, 5);
      rd_pl("R10 free slot payload", 1, 5);
      rd_pl("R10 free slot last byte", 1, 12);

      // R11: error and clear in the same cycle keeps the flag set
      do_launch("R11 launch", w);
      do_outcome("R11 set beats clear", 1, 1'b1);
      clr_flags(3'b000, 1'b1);

      // R12: new request posted after a failure competes at the next arbitration
      wr_ctrl(2, 8'h0B);
      do_launch("R12 re-evaluation picks newcomer", w);
      do_outcome("R12 newcomer success", 0, 1'b0);
      do_launch("R12 earlier slot retried", w);
      do_outcome("R12 earlier slot success", 0, 1'b0);
      clr_flags(3'b111, 1'b1);

      // Constrained random phase
      for (int it = 0; it < 150; it++) begin
         int nw;
         nw = int'($urandom % 4);
         for (int k = 0; k < nw; k++) begin
            int s;
            bit [7:0] d;
            s = int'($urandom % NS);
            d = 8'(($urandom % 2) << 3) | 8'($urandom % 4);
            wr_ctrl(s, d);
         end
         if ($urandom % 3 == 0) begin
            int s;
            int a;
            s = int'($urandom % NS);
            a = int'($urandom % NB);
            wr_pl(s, a, 8'($urandom));
            rd_pl("R10 random payload", s, a);
         end
         done_ie = NS'($urandom);
         merr_ie = 1'($urandom);
         do_launch("R2 R3 random arbitration", w);
         if (w >= 0) do_outcome("R5 R6 R7 random outcome", int'($urandom % 3), 1'b0);
         if ($urandom % 4 == 0) clr_flags(NS'($urandom), 1'($urandom));
      end

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule